// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block runs once after the chip's internal reset is released. On a start pulse from the reset controller it issues a fixed, ordered list of register writes on a simple parallel host bus. The bus has an address, write data, a write strobe and a ready input. The writes bring two groups of eight codec channels into normal operation. The list includes a two-phase calibration. Each phase is started through a command word in processor RAM and is followed by a long fixed wait before the next writes go out.

The list is held as a short table of steps. Each step is either a burst of writes to consecutive addresses with one value, or a timed wait. The wait length is given in milliseconds and is turned into clock cycles from a clock-frequency parameter. After the last write is accepted, a done flag rises and stays high until the next reset. An asynchronous reset at any point returns the block to idle. A fresh start then replays the whole list from the first write.

Top module: `pwrup_sequencer`

## Requirements
- R1: After reset the block is idle: bus_wr and done are low, and they stay low until start is sampled high.
- R2: The first 16 writes fill the time-slot table. They go to TSA_BASE+i with data i, for i = 0 to 15, in increasing order, and they come before any channel control write.
- R3: Writes of 0x0004 to 0x1510 and then to 0x1550 follow the table fill. The same two writes, in the same order, are also the last two writes of the list.
- R4: After R3's first pair, 0x8000 is written to 0x1500 through 0x1507 and then to 0x1540 through 0x1547.
- R5: Next, 0xAA20 is written to 0x0580 and then 0xF49D to 0x0581.
- R6: Next, 0x0080 is written to 0x1518 through 0x151F and then to 0x1558 through 0x155F.
- R7: Next, 0x0700 is written to 0x0002. Then bus_wr stays low for exactly WAIT_MS*CLK_HZ/1000 cycles. Then 0x8001 is written to 0x1508 through 0x150F and to 0x1548 through 0x154F.
- R8: Next, 0x0720 is written to 0x0002. Then bus_wr stays low for the same number of cycles as in R7. Then 0x8000 is written to 0x1517 and then to 0x1557.
- R9: A write completes on a clock edge where bus_wr and bus_rdy are both high. While bus_rdy is low, bus_wr, bus_addr and bus_wdata hold their values.
- R10: The cycle after the 74th write completes, done goes high and bus_wr goes low. Both then hold until reset.
- R11: A start pulse while the list is running, or after done, has no effect on the writes or on done.
- R12: Reset in the middle of the list returns the block to idle at once. The next start replays the full list of 74 writes from the first table write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle start pulse from the reset controller |
| bus_rdy | input | 1 | The host bus accepts the current write |
| bus_addr | output | 16 | Write address |
| bus_wdata | output | 16 | Write data |
| bus_wr | output | 1 | Write strobe |
| done | output | 1 | The full list has been written |

## Verification
On every cycle the assertions check the local rules: an idle block stays silent without start, a start launches the first table write, a stalled write holds its address and data, the calibration command is followed by a silent cycle, and done is sticky and never overlaps a write. Only the bench's scenarios can show the order and content of all 74 writes and the exact length of both waits. They use a queue-based reference model compared on every clock, with ready patterns that include long stalls. The same holds for ignoring a stray start and for a clean replay after a reset partway through the list.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 16;
    localparam int NUM_STEPS = 19;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);
    localparam int BURST_MAX = 16;
    localparam int OFF_W     = $clog2(BURST_MAX);
    localparam int LEN_W     = OFF_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              is_wait;
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] value;
        logic              index_data;
    } step_t;

    function automatic step_t mk(input logic w, input logic [ADDR_W-1:0] b,
                                 input int n, input logic [DATA_W-1:0] v,
                                 input logic idx);
        step_t s;
        s.is_wait    = w;
        s.base       = b;
        s.len        = LEN_W'(n);
        s.value      = v;
        s.index_data = idx;
        return s;
    endfunction

    // Ordered step list; the order is the behaviour.
    function automatic step_t step_lookup(input logic [STEP_W-1:0] idx,
                                          input logic [ADDR_W-1:0] slot_base);
        step_t s;
        case (idx)
            5'd0:    s = mk(1'b0, slot_base, 16, 16'h0000, 1'b1);
            5'd1:    s = mk(1'b0, 16'h1510,   1, 16'h0004, 1'b0);
            5'd2:    s = mk(1'b0, 16'h1550,   1, 16'h0004, 1'b0);
            5'd3:    s = mk(1'b0, 16'h1500,   8, 16'h8000, 1'b0);
            5'd4:    s = mk(1'b0, 16'h1540,   8, 16'h8000, 1'b0);
            5'd5:    s = mk(1'b0, 16'h0580,   1, 16'hAA20, 1'b0);
            5'd6:    s = mk(1'b0, 16'h0581,   1, 16'hF49D, 1'b0);
            5'd7:    s = mk(1'b0, 16'h1518,   8, 16'h0080, 1'b0);
            5'd8:    s = mk(1'b0, 16'h1558,   8, 16'h0080, 1'b0);
            5'd9:    s = mk(1'b0, 16'h0002,   1, 16'h0700, 1'b0);
            5'd10:   s = mk(1'b1, 16'h0000,   1, 16'h0000, 1'b0);
            5'd11:   s = mk(1'b0, 16'h1508,   8, 16'h8001, 1'b0);
            5'd12:   s = mk(1'b0, 16'h1548,   8, 16'h8001, 1'b0);
            5'd13:   s = mk(1'b0, 16'h0002,   1, 16'h0720, 1'b0);
            5'd14:   s = mk(1'b1, 16'h0000,   1, 16'h0000, 1'b0);
            5'd15:   s = mk(1'b0, 16'h1517,   1, 16'h8000, 1'b0);
            5'd16:   s = mk(1'b0, 16'h1557,   1, 16'h8000, 1'b0);
            5'd17:   s = mk(1'b0, 16'h1510,   1, 16'h0004, 1'b0);
            5'd18:   s = mk(1'b0, 16'h1550,   1, 16'h0004, 1'b0);
            default: s = mk(1'b0, 16'h0000,   1, 16'h0000, 1'b0);
        endcase
        return s;
    endfunction

    function automatic logic step_is_wait(input logic [STEP_W-1:0] idx);
        return (idx == STEP_W'(10)) || (idx == STEP_W'(14));
    endfunction

endpackage

// File: rtl/pwrup_seq_rom.sv
module pwrup_seq_rom
    import pwrup_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TSA_BASE = 16'h1C00
) (
    input  logic [STEP_W-1:0] step_idx,
    input  logic [OFF_W-1:0]  offset,
    output logic              is_wait,
    output logic              next_is_wait,
    output logic              last_beat,
    output logic              last_step,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    step_t cur;

    always_comb begin
        cur          = step_lookup(step_idx, TSA_BASE);
        is_wait      = cur.is_wait;
        next_is_wait = step_is_wait(step_idx + 1'b1);
        last_beat    = (LEN_W'(offset) == (cur.len - 1'b1));
        last_step    = (step_idx == STEP_W'(NUM_STEPS - 1));
        addr         = cur.base + ADDR_W'(offset);
        data         = cur.index_data ? DATA_W'(offset) : cur.value;
    end

endmodule

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load)
            count_d = CW'(CYCLES - 1);
        else if (count_q != '0)
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/pwrup_sequencer.sv
module pwrup_sequencer
    import pwrup_seq_pkg::*;
#(
    parameter int                CLK_HZ   = 200_000_000,
    parameter int                WAIT_MS  = 70,
    parameter logic [ADDR_W-1:0] TSA_BASE = 16'h1C00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bus_rdy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              done
);

    localparam int WAIT_CYCLES = (CLK_HZ / 1000) * WAIT_MS;

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic [OFF_W-1:0]  off;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      timer_load, timer_done;
    logic      cur_wait, nxt_wait, last_beat, last_step;
    logic      seq_idle;

    pwrup_seq_rom #(.TSA_BASE(TSA_BASE)) rom_i (
        .step_idx     (r_q.step),
        .offset       (r_q.off),
        .is_wait      (cur_wait),
        .next_is_wait (nxt_wait),
        .last_beat    (last_beat),
        .last_step    (last_step),
        .addr         (bus_addr),
        .data         (bus_wdata)
    );

    pwrup_wait_timer #(.CYCLES(WAIT_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .expired (timer_done)
    );

    always_comb begin
        r_d        = r_q;
        timer_load = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_WRITE;
                    r_d.step  = '0;
                    r_d.off   = '0;
                end
            end
            ST_WRITE: begin
                if (bus_rdy) begin
                    if (!last_beat) begin
                        r_d.off = r_q.off + 1'b1;
                    end else begin
                        r_d.off = '0;
                        if (last_step) begin
                            r_d.state = ST_DONE;
                        end else begin
                            r_d.step = r_q.step + 1'b1;
                            if (nxt_wait) begin
                                r_d.state  = ST_WAIT;
                                timer_load = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (timer_done && cur_wait) begin
                    r_d.state = ST_WRITE;
                    r_d.step  = r_q.step + 1'b1;
                end
            end
            ST_DONE: begin
                r_d.state = ST_DONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.step  <= '0;
            r_q.off   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_wr   = (r_q.state == ST_WRITE);
    assign done     = (r_q.state == ST_DONE);
    assign seq_idle = (r_q.state == ST_IDLE);

endmodule

// File: rtl/pwrup_sequencer_chk.sv
module pwrup_sequencer_chk #(
    parameter logic [15:0] TSA_BASE = 16'h1C00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        bus_rdy,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic        done,
    input logic        idle
);

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> (idle && !bus_wr && !done)); // R1

    AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> (bus_wr && bus_addr == TSA_BASE && bus_wdata == 16'h0000)); // R2

    AST_CAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rdy && bus_addr == 16'h0002) |=> !bus_wr); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rdy) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata))); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R10

    AST_NO_WR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && bus_wr)); // R10

endmodule

bind pwrup_sequencer pwrup_sequencer_chk #(.TSA_BASE(TSA_BASE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_rdy   (bus_rdy),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .done      (done),
    .idle      (seq_idle)
);

// File: tb/pwrup_sequencer_tb_top.sv
`timescale 1ns/1ps
module pwrup_sequencer_tb_top;

    localparam int          CLK_HZ  = 100_000;
    localparam int          WAIT_MS = 70;
    localparam int          W       = (CLK_HZ / 1000) * WAIT_MS;
    localparam logic [15:0] TSA     = 16'h1C00;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, bus_rdy = 1'b0;
    logic [15:0] bus_addr, bus_wdata;
    logic        bus_wr, done;

    always #2.5 clk = ~clk;

    pwrup_sequencer #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS), .TSA_BASE(TSA)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_rdy(bus_rdy),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .done(done)
    );

    typedef struct {
        bit          is_wait;
        int          n;
        logic [15:0] a;
        logic [15:0] d;
        string       tag;
    } item_t;

    item_t       q[$];
    int          checks = 0, errors = 0;
    int          m_state = 0;
    int          run_cnt = 0;
    int          rdy_mode = 1;
    logic        had_stall = 1'b0;
    logic [15:0] st_a, st_d;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic void pw(input logic [15:0] a, input logic [15:0] d, input string tag);
        item_t it;
        it.is_wait = 0; it.n = 0; it.a = a; it.d = d; it.tag = tag;
        q.push_back(it);
    endfunction

    function automatic void pwait(input string tag);
        item_t it;
        it.is_wait = 1; it.n = W; it.a = '0; it.d = '0; it.tag = tag;
        q.push_back(it);
    endfunction

    function automatic void build();
        q.delete();
        for (int i = 0; i < 16; i++) pw(TSA + 16'(i), 16'(i), "R2");
        pw(16'h1510, 16'h0004, "R3"); pw(16'h1550, 16'h0004, "R3");
        for (int i = 0; i < 8; i++) pw(16'h1500 + 16'(i), 16'h8000, "R4");
        for (int i = 0; i < 8; i++) pw(16'h1540 + 16'(i), 16'h8000, "R4");
        pw(16'h0580, 16'hAA20, "R5"); pw(16'h0581, 16'hF49D, "R5");
        for (int i = 0; i < 8; i++) pw(16'h1518 + 16'(i), 16'h0080, "R6");
        for (int i = 0; i < 8; i++) pw(16'h1558 + 16'(i), 16'h0080, "R6");
        pw(16'h0002, 16'h0700, "R7");
        pwait("R7");
        for (int i = 0; i < 8; i++) pw(16'h1508 + 16'(i), 16'h8001, "R7");
        for (int i = 0; i < 8; i++) pw(16'h1548 + 16'(i), 16'h8001, "R7");
        pw(16'h0002, 16'h0720, "R8");
        pwait("R8");
        pw(16'h1517, 16'h8000, "R8"); pw(16'h1557, 16'h8000, "R8");
        pw(16'h1510, 16'h0004, "R3"); pw(16'h1550, 16'h0004, "R3");
    endfunction

    // Reference model, compared every clock at the falling edge
    always @(negedge clk) begin
        if (!finished) begin
            bit    exp_wr;
            string tag;
            if (!rst_n) begin
                m_state = 0; q.delete(); had_stall = 1'b0;
            end
            exp_wr = (m_state == 1) && (q.size() > 0) && !q[0].is_wait;
            if (m_state == 0)      tag = "R1";
            else if (m_state == 2) tag = "R10";
            else                   tag = q[0].tag;
            chk(done == (m_state == 2), "R10", "done", int'(done), int'(m_state == 2));
            chk(bus_wr == exp_wr, tag, "bus_wr", int'(bus_wr), int'(exp_wr));
            if (bus_wr && exp_wr) begin
                chk(bus_addr == q[0].a, q[0].tag, "addr", int'(bus_addr), int'(q[0].a));
                chk(bus_wdata == q[0].d, q[0].tag, "data", int'(bus_wdata), int'(q[0].d));
            end
            if (had_stall && bus_wr) begin
                chk(bus_addr == st_a, "R9", "held addr", int'(bus_addr), int'(st_a));
                chk(bus_wdata == st_d, "R9", "held data", int'(bus_wdata), int'(st_d));
            end
            had_stall = bus_wr && !bus_rdy;
            st_a = bus_addr; st_d = bus_wdata;
            if (rst_n) begin
                case (m_state)
                    0: if (start) begin build(); run_cnt = 0; m_state = 1; end
                    1: begin
                        if (q[0].is_wait) begin
                            q[0].n--;
                            if (q[0].n == 0) void'(q.pop_front());
                        end else if (bus_rdy) begin
                            void'(q.pop_front());
                            run_cnt++;
                        end
                        if (q.size() == 0) m_state = 2;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Ready driver: always ready, or a pseudo-random pattern with stalls
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_rdy = (rdy_mode == 0) ? 1'b1 : (lfsr[2:0] > 3'd2);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start = 1'b1; cyc(1); start = 1'b0;
    endtask

    task automatic report();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        cyc(4); rst_n = 1'b1; cyc(6);
        @(negedge clk);
        chk(!bus_wr && !done, "R1", "idle outputs", int'({bus_wr, done}), 0);
        cyc(1);
        // Run 1: stalled ready, stray start partway
        pulse_start();
        while (run_cnt < 20) cyc(1);
        pulse_start(); // R11 stray start ignored
        while (!done) cyc(1);
        @(negedge clk);
        chk(run_cnt == 74, "R10", "writes in run", run_cnt, 74);
        cyc(1);
        pulse_start(); // R11 start after done
        cyc(5); @(negedge clk);
        chk(done && !bus_wr, "R11", "done after late start", int'({done, bus_wr}), 2);
        // Run 2: reset partway through
        cyc(1); rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
        @(negedge clk);
        chk(!done && !bus_wr, "R12", "idle after reset", int'({done, bus_wr}), 0);
        cyc(1);
        pulse_start();
        while (run_cnt < 40) cyc(1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!done && !bus_wr, "R12", "mid-run reset", int'({done, bus_wr}), 0);
        cyc(2); rst_n = 1'b1; cyc(2);
        // Run 3: always ready, full replay
        rdy_mode = 0;
        pulse_start();
        @(negedge clk);
        chk(bus_wr && bus_addr == TSA, "R12", "replay first addr", int'(bus_addr), int'(TSA));
        while (!done) cyc(1);
        @(negedge clk);
        chk(run_cnt == 74, "R12", "writes in replay", run_cnt, 74);
        cyc(3);
        report();
    end

    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        report();
    end

endmodule